// File: doc/BRIEF.md
# Signed Result Seven-Segment Display Driver

This block shows a small two's complement number on a multi-panel, common-anode seven-segment display. The input is read as a signed value. A value of zero or more appears as one decimal digit on a single panel, the magnitude panel, and every other panel stays dark. A negative value is turned into its magnitude. That magnitude is shown on the magnitude panel, and a minus sign is shown on a neighbouring sign panel. The two panels take turns fast enough that both appear lit at once.

A free-running refresh counter sets the turn length. With the default divider and a 50 MHz clock, the active panel changes about every millisecond. Segments and anodes are both driven from registers, so they always change on the same clock edge. The arithmetic that produces the value, and any debouncing of its source, lie outside this block.

Top module: `signed_digit_display`

## Requirements
- R1: While reset is asserted, every anode output is high (all panels off), every segment output is high (all segments dark), and the refresh counter is cleared.
- R2: When the sign bit (MSB) of the input is 0, only the magnitude panel (anode index MAG_PANEL, driven low) is ever enabled, and it stays enabled without interruption.
- R3: When the sign bit is 1, the enabled panel alternates between the magnitude panel and the sign panel (anode index SIGN_PANEL). No other panel is enabled.
- R4: While the sign panel is enabled, the segment bus shows a minus sign: only segment g is lit, so seg_n equals 7'b0111111.
- R5: While the magnitude panel is enabled, the segment bus shows the input's absolute value as an active-low digit, with bit order {g,f,e,d,c,b,a} (bit 6 = g, bit 0 = a). Lit segments per digit: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all seven.
- R6: The most negative input (-8 at the default 4-bit width) is shown as a minus sign on the sign panel and the digit 8 on the magnitude panel.
- R7: At most one anode is low in any cycle. For a negative input, the enabled panel changes exactly every REFRESH_DIV clock cycles.
- R8: The outputs are registered. A change of a non-negative input shows on the magnitude panel one clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| value | input | VAL_W | Two's complement number to display |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| an_n | output | NUM_PANELS | Active-low panel enables, one bit per panel |

## Verification
The bench builds the block with REFRESH_DIV of 4, four panels, the magnitude panel at index 0 and the sign panel at index 1. The short divider means many full alternation periods fit into one check window of a few dozen cycles. This makes it practical to measure the exact slot length and to confirm that segment contents match each active panel across the whole signed range, including -8. Keeping four panels leaves two panels that are never meant to light, so any stray enable on them is visible.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   typedef logic [6:0] seg_t;   // {g,f,e,d,c,b,a}, active high inside the block

   typedef enum logic {
      SLOT_DIGIT = 1'b0,
      SLOT_SIGN  = 1'b1
   } slot_e;

   localparam seg_t SEG_MINUS_HI = 7'b100_0000;
   localparam seg_t SEG_DARK_HI  = 7'b000_0000;

   function automatic seg_t digit_to_seg_hi(input logic [3:0] d);
      seg_t s;
      case (d)
         4'd0:    s = 7'b011_1111;
         4'd1:    s = 7'b000_0110;
         4'd2:    s = 7'b101_1011;
         4'd3:    s = 7'b100_1111;
         4'd4:    s = 7'b110_0110;
         4'd5:    s = 7'b110_1101;
         4'd6:    s = 7'b111_1101;
         4'd7:    s = 7'b000_0111;
         4'd8:    s = 7'b111_1111;
         4'd9:    s = 7'b110_1111;
         default: s = SEG_DARK_HI;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sdd_refresh.sv
module sdd_refresh
   import sdd_pkg::*;
#(
   parameter int REFRESH_DIV = 50000
) (
   input  logic  clk,
   input  logic  rst,
   output slot_e slot
);
   localparam int CW = (REFRESH_DIV > 2) ? $clog2(REFRESH_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(REFRESH_DIV - 1);

   logic [CW-1:0] tick_cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         tick_cnt <= '0;
         slot     <= SLOT_DIGIT;
      end else if (tick_cnt == LAST) begin
         tick_cnt <= '0;
         slot     <= (slot == SLOT_DIGIT) ? SLOT_SIGN : SLOT_DIGIT;
      end else begin
         tick_cnt <= tick_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdd_value_split.sv
module sdd_value_split #(
   parameter int VAL_W = 4
) (
   input  logic [VAL_W-1:0] value,
   output logic             neg,
   output logic [3:0]       mag
);
   logic [VAL_W-1:0] abs_v;

   assign neg   = value[VAL_W-1];
   // The signed reading is formed for every input and chosen only on a set sign bit.
   assign abs_v = neg ? (~value + 1'b1) : value;

   generate
      if (VAL_W < 4) begin : g_pad
         assign mag = {{(4-VAL_W){1'b0}}, abs_v};
      end else begin : g_full
         assign mag = abs_v;
      end
   endgenerate
endmodule

// File: rtl/sdd_seg_mux.sv
module sdd_seg_mux
   import sdd_pkg::*;
#(
   parameter int NUM_PANELS = 4,
   parameter int MAG_PANEL  = 0,
   parameter int SIGN_PANEL = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  slot_e                 slot,
   input  logic                  neg,
   input  logic [3:0]            mag,
   output logic [6:0]            seg_n,
   output logic [NUM_PANELS-1:0] an_n
);
   logic [NUM_PANELS-1:0] mag_sel, sign_sel, an_hi;
   seg_t                  seg_hi;

   generate
      for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
         assign mag_sel[p]  = (p == MAG_PANEL);
         assign sign_sel[p] = (p == SIGN_PANEL);
      end
   endgenerate

   always_comb begin
      if (neg && (slot == SLOT_SIGN)) begin
         an_hi  = sign_sel;
         seg_hi = SEG_MINUS_HI;
      end else begin
         an_hi  = mag_sel;
         seg_hi = digit_to_seg_hi(mag);
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         seg_n <= '1;
         an_n  <= '1;
      end else begin
         seg_n <= ~seg_hi;
         an_n  <= ~an_hi;
      end
   end
endmodule

// File: rtl/signed_digit_display.sv
module signed_digit_display
   import sdd_pkg::*;
#(
   parameter int VAL_W       = 4,
   parameter int NUM_PANELS  = 4,
   parameter int MAG_PANEL   = 0,
   parameter int SIGN_PANEL  = 1,
   parameter int REFRESH_DIV = 50000
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [VAL_W-1:0]      value,
   output logic [6:0]            seg_n,
   output logic [NUM_PANELS-1:0] an_n
);
   generate
      if (VAL_W < 2 || VAL_W > 4) begin : g_bad_width
         $error("VAL_W must be 2..4 so the magnitude fits one decimal digit");
      end
      if (NUM_PANELS < 2) begin : g_bad_panels
         $error("NUM_PANELS must be at least 2");
      end
      if (MAG_PANEL < 0 || MAG_PANEL >= NUM_PANELS ||
          SIGN_PANEL < 0 || SIGN_PANEL >= NUM_PANELS ||
          MAG_PANEL == SIGN_PANEL) begin : g_bad_index
         $error("MAG_PANEL and SIGN_PANEL must be distinct valid panel indices");
      end
      if (REFRESH_DIV < 2) begin : g_bad_div
         $error("REFRESH_DIV must be at least 2");
      end
   endgenerate

   slot_e      slot;
   logic       neg;
   logic [3:0] mag;

   sdd_refresh #(.REFRESH_DIV(REFRESH_DIV)) u_refresh (
      .clk  (clk),
      .rst  (rst),
      .slot (slot)
   );

   sdd_value_split #(.VAL_W(VAL_W)) u_split (
      .value (value),
      .neg   (neg),
      .mag   (mag)
   );

   sdd_seg_mux #(
      .NUM_PANELS (NUM_PANELS),
      .MAG_PANEL  (MAG_PANEL),
      .SIGN_PANEL (SIGN_PANEL)
   ) u_mux (
      .clk   (clk),
      .rst   (rst),
      .slot  (slot),
      .neg   (neg),
      .mag   (mag),
      .seg_n (seg_n),
      .an_n  (an_n)
   );
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker #(
   parameter int VAL_W      = 4,
   parameter int NUM_PANELS = 4,
   parameter int MAG_PANEL  = 0,
   parameter int SIGN_PANEL = 1
) (
   input logic                  clk,
   input logic                  rst,
   input logic [VAL_W-1:0]      value,
   input logic [6:0]            seg_n,
   input logic [NUM_PANELS-1:0] an_n
);
   localparam logic [NUM_PANELS-1:0] MAG_ON  = ~(NUM_PANELS'(1) << MAG_PANEL);
   localparam logic [NUM_PANELS-1:0] SIGN_ON = ~(NUM_PANELS'(1) << SIGN_PANEL);

   AST_RESET_DARK: assert property (@(posedge clk)
      rst |=> (an_n == '1 && seg_n == 7'h7F)); // R1

   AST_ONE_PANEL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~an_n)); // R7

   AST_POS_MAG_ONLY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(value[VAL_W-1])) |-> (an_n == MAG_ON)); // R2

   AST_NEG_TWO_PANELS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(value[VAL_W-1])) |-> (an_n == MAG_ON || an_n == SIGN_ON)); // R3

   AST_SIGN_IS_MINUS: assert property (@(posedge clk) disable iff (rst)
      (an_n == SIGN_ON) |-> (seg_n == 7'b011_1111)); // R4
endmodule

bind signed_digit_display sdd_checker #(
   .VAL_W      (VAL_W),
   .NUM_PANELS (NUM_PANELS),
   .MAG_PANEL  (MAG_PANEL),
   .SIGN_PANEL (SIGN_PANEL)
) u_sdd_checker (
   .clk   (clk),
   .rst   (rst),
   .value (value),
   .seg_n (seg_n),
   .an_n  (an_n)
);

// File: tb/signed_digit_display_test.sv
module signed_digit_display_test;
   localparam int CLK_PERIOD = 10;
   localparam int VAL_W = 4;
   localparam int NP    = 4;
   localparam int MAGP  = 0;
   localparam int SGNP  = 1;
   localparam int DIV   = 4;
   localparam int WIN   = 6 * DIV;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [VAL_W-1:0] value = '0;
   logic [6:0]    seg_n;
   logic [NP-1:0] an_n;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   signed_digit_display #(
      .VAL_W(VAL_W), .NUM_PANELS(NP), .MAG_PANEL(MAGP),
      .SIGN_PANEL(SGNP), .REFRESH_DIV(DIV)
   ) uut (
      .clk(clk), .rst(rst), .value(value), .seg_n(seg_n), .an_n(an_n)
   );

   function automatic logic [6:0] exp_digit(input int d);
      // lit-segment list per digit, bit6=g .. bit0=a, then inverted
      logic [6:0] on;
      case (d)
         0: on = 7'b0111111; 1: on = 7'b0000110; 2: on = 7'b1011011;
         3: on = 7'b1001111; 4: on = 7'b1100110; 5: on = 7'b1101101;
         6: on = 7'b1111101; 7: on = 7'b0000111; 8: on = 7'b1111111;
         default: on = 7'b0000000;
      endcase
      return ~on;
   endfunction

   function automatic int signed_of(input logic [VAL_W-1:0] v);
      return v[VAL_W-1] ? int'(v) - (1 << VAL_W) : int'(v);
   endfunction

   localparam logic [NP-1:0] MAG_ON  = ~(NP'(1) << MAGP);
   localparam logic [NP-1:0] SIGN_ON = ~(NP'(1) << SGNP);
   localparam logic [6:0]    MINUS   = 7'b0111111;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Apply a value, let it settle, then observe a window of cycles.
   task automatic observe(input logic [VAL_W-1:0] v);
      int sv, mg, last_chg, bad_iv, seen_mag, seen_sign, seen_other;
      logic [NP-1:0] prev;
      logic [6:0] bad_seg;
      bit seg_ok;
      sv = signed_of(v);
      mg = (sv < 0) ? -sv : sv;
      @(negedge clk);
      value = v;
      repeat (2*DIV + 2) @(negedge clk);
      seg_ok = 1; bad_seg = '0; bad_iv = 0; last_chg = -1;
      seen_mag = 0; seen_sign = 0; seen_other = 0;
      prev = an_n;
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         if (an_n == MAG_ON) begin
            seen_mag++;
            if (seg_n != exp_digit(mg)) begin seg_ok = 0; bad_seg = seg_n; end
         end else if (an_n == SIGN_ON) begin
            seen_sign++;
            if (seg_n != MINUS) begin seg_ok = 0; bad_seg = seg_n; end
         end else seen_other++;
         if (an_n != prev) begin
            if (last_chg >= 0 && (i - last_chg) != DIV) bad_iv = i - last_chg;
            last_chg = i;
         end
         prev = an_n;
      end
      if (sv >= 0) begin
         check(seen_mag == WIN, "R2", $sformatf("value %0d magnitude panel only", sv),
               seen_mag, WIN);
         check(seg_ok, "R5", $sformatf("digit for %0d", sv), bad_seg, exp_digit(mg));
      end else begin
         check(seen_mag > 0 && seen_sign > 0 && seen_other == 0, "R3",
               $sformatf("value %0d alternation mag/sign/other", sv),
               {seen_mag[7:0], seen_sign[7:0], seen_other[7:0]}, 0);
         check(seg_ok, (sv == -(1 << (VAL_W-1))) ? "R6" : "R4/R5",
               $sformatf("segments for %0d", sv), bad_seg, exp_digit(mg));
         check(bad_iv == 0 && last_chg >= 0, "R7",
               $sformatf("slot interval for %0d", sv), bad_iv, DIV);
      end
   endtask

   initial begin
      void'($urandom(32'h5D1_6A7E));
      // R1: reset state
      repeat (3) @(negedge clk);
      check(an_n == '1, "R1", "anodes in reset", an_n, {NP{1'b1}});
      check(seg_n == 7'h7F, "R1", "segments in reset", seg_n, 7'h7F);
      rst = 1'b0;

      // Directed corners
      observe(4'd0);
      observe(4'd7);
      observe(4'hF);   // -1
      observe(4'h8);   // -8, R6
      observe(4'h9);   // -7

      // R8: one-edge latency on a non-negative change
      @(negedge clk);
      value = 4'd3;
      @(negedge clk);
      value = 4'd5;
      @(negedge clk);
      check(seg_n == exp_digit(5) && an_n == MAG_ON, "R8", "digit one edge after change",
            {an_n, seg_n}, {MAG_ON, exp_digit(5)});

      // Every value of the range, then random ones
      for (int k = 0; k < 16; k++) observe(4'(k));
      for (int k = 0; k < 20; k++) observe(4'($urandom_range(0, 15)));

      // R1 again: reset mid-operation
      @(negedge clk);
      value = 4'hC;
      rst = 1'b1;
      @(negedge clk);
      check(an_n == '1 && seg_n == 7'h7F, "R1", "reset while running",
            {an_n, seg_n}, {{NP{1'b1}}, 7'h7F});
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule